// File: doc/BRIEF.md
# Dual-Domain Soft-Reset Sequencer

This block turns a software request for a controller-wide soft reset into an ordered sequence that spans a bus clock domain and a PHY clock domain. Software sets a self-clearing request bit in a small register window. The bus-master side gets a stop request and may finish the data phase it is in. The PHY side is told to abandon USB traffic as soon as the request crosses over. Once the bus master reports idle, the block issues a one-cycle reset pulse to the state machines and starts a FIFO flush. It returns the configuration and interrupt registers to their reset values but keeps three protected configuration fields. The request bit drops on its own only after the FIFO flush has finished and the PHY domain has completed a full request/acknowledge handshake.

A second self-clearing bit resets only the full-speed PHY-interface state machines. It uses its own handshake and leaves registers and FIFOs alone. In the PHY domain, a ready output stays low while a core reset is in progress and for a fixed hold time after it ends. This gives the PHY logic time to settle before it is used again. The USB engines, the FIFO storage and the bus fabric sit outside the block and connect through plain idle/stop and flush/done handshakes.

Top module: `softreset_seq`

## Requirements
- R1: After hard reset, the control word (address 0) reads 0 in bits 30..0. The config word (address 1) reads its misc field bits 15..8 as 8'h5A with protected bits 4..0 at 0. The interrupt word (address 2) reads 0, and bm_stop, sm_rst and fifo_flush are low.
- R2: Control bit 0 is write-1-to-set. Writing 0 has no effect. Writing 1 while a reset is under way has no extra effect: still exactly one sm_rst pulse per reset.
- R3: bm_stop rises on the clock edge that accepts the request and stays high until bm_idle is sampled high on an edge; it is never high while bit 0 is clear.
- R4: sm_rst is a single-cycle pulse in the cycle after the edge on which bm_idle was sampled high during draining; fifo_flush is high in that cycle and stays high until fifo_flush_done has been seen.
- R5: At the edge that ends the sm_rst pulse, the misc field returns to 8'h5A and all interrupt flags clear (irq_set is ignored on that edge). The protected fields keep their values: PHY clock select in bits 1..0, device speed in bits 3..2 and soft-disconnect in bit 4.
- R6: usb_abort rises in the PHY domain two PHY clocks after the request is accepted, without waiting for the bus master to drain; phy_sm_rst is a one-PHY-cycle pulse at that point.
- R7: Control bit 0 clears by itself only after fifo_flush_done has been seen and the PHY domain has acknowledged, and within a bounded number of bus cycles.
- R8: Control bit 31 reads the live bm_idle input and cannot be written.
- R9: phy_ready is low whenever usb_abort is high, and stays low for at least 3 PHY clocks after control bit 0 clears.
- R10: Control bit 1 is write-1-to-set and self-clearing. It drives fs_sm_rst in the PHY domain and causes no sm_rst, no fifo_flush and no register change.
- R11: Interrupt flags in bits INT_W-1..0 of address 2 are set by irq_set, cleared by writing 1 to them, and irq_pending is their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus domain clock |
| rst_bus_n | input | 1 | Bus domain asynchronous active-low reset |
| clk_phy | input | 1 | PHY domain clock |
| rst_phy_n | input | 1 | PHY domain asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_set | input | INT_W | Interrupt event inputs |
| irq_pending | output | 1 | OR of interrupt flags |
| bm_idle | input | 1 | Bus master reports no transfer in flight |
| bm_stop | output | 1 | Ask bus master to stop after current data phase |
| sm_rst | output | 1 | One-cycle reset pulse to bus-domain state machines |
| fifo_flush | output | 1 | Flush request to transmit and receive FIFOs |
| fifo_flush_done | input | 1 | FIFO flush complete |
| usb_abort | output | 1 | PHY-domain abort of USB traffic |
| phy_sm_rst | output | 1 | PHY-domain one-cycle state machine reset pulse |
| fs_sm_rst | output | 1 | PHY-domain reset of full-speed interface logic |
| phy_ready | output | 1 | PHY domain may be accessed |
| cfg_phy_clk | output | 2 | Protected PHY clock select |
| cfg_dev_speed | output | 2 | Protected device speed |
| cfg_soft_disc | output | 1 | Protected soft-disconnect |
| cfg_misc | output | 8 | Non-protected configuration field |

## Verification
A stuck sequencer state shows at the ports within one bus cycle. Either bm_stop stays high after bm_idle was high, or sm_rst lasts longer than one cycle or comes twice per request. A wrong clear mask shows as a changed protected field or a leftover interrupt flag on the first read after the pulse. A broken handshake shows as control bit 0 clearing before flush done or the PHY abort, or as phy_ready rising within three PHY clocks of the clear. A lost synchronizer stage shows the same way.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_DRAIN   = 3'd1,
    SQ_CLEAR   = 3'd2,
    SQ_FLUSH   = 3'd3,
    SQ_RELEASE = 3'd4
  } core_st_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_REL  = 2'd2
  } fs_st_t;

  localparam int          REG_AW    = 2;
  localparam logic [1:0]  ADDR_CTRL = 2'd0;
  localparam logic [1:0]  ADDR_CFG  = 2'd1;
  localparam logic [1:0]  ADDR_INT  = 2'd2;

  localparam int BIT_CORE = 0;
  localparam int BIT_FS   = 1;
  localparam int BIT_IDLE = 31;

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int SH_W = W * STAGES;

  logic [SH_W-1:0] shift_q;
  logic [SH_W-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[SH_W-W-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign q = shift_q[SH_W-1 -: W];

endmodule

// File: rtl/srs_seq.sv
module srs_seq
  import srs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic core_wr1,
  input  logic fs_wr1,
  input  logic bm_idle,
  input  logic flush_done,
  input  logic core_ack_s,
  input  logic fs_ack_s,
  output logic core_bit,
  output logic fs_bit,
  output logic core_req,
  output logic fs_req,
  output logic bm_stop,
  output logic sm_rst,
  output logic fifo_flush
);

  core_st_t core_q, core_d;
  fs_st_t   fs_q, fs_d;
  logic     flush_seen_q, flush_seen_d;
  logic     flush_ok;

  assign flush_ok = flush_seen_q | flush_done;

  always_comb begin
    core_d = core_q;
    unique case (core_q)
      SQ_IDLE:    if (core_wr1)               core_d = SQ_DRAIN;
      SQ_DRAIN:   if (bm_idle)                core_d = SQ_CLEAR;
      SQ_CLEAR:                               core_d = SQ_FLUSH;
      SQ_FLUSH:   if (flush_ok && core_ack_s) core_d = SQ_RELEASE;
      SQ_RELEASE: if (!core_ack_s)            core_d = SQ_IDLE;
      default:                                core_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    flush_seen_d = flush_seen_q;
    if (core_q == SQ_IDLE)                               flush_seen_d = 1'b0;
    else if ((core_q == SQ_CLEAR || core_q == SQ_FLUSH) && flush_done)
                                                         flush_seen_d = 1'b1;
  end

  always_comb begin
    fs_d = fs_q;
    unique case (fs_q)
      FS_IDLE: if (fs_wr1)    fs_d = FS_REQ;
      FS_REQ:  if (fs_ack_s)  fs_d = FS_REL;
      FS_REL:  if (!fs_ack_s) fs_d = FS_IDLE;
      default:                fs_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q       <= SQ_IDLE;
      fs_q         <= FS_IDLE;
      flush_seen_q <= 1'b0;
    end else begin
      core_q       <= core_d;
      fs_q         <= fs_d;
      flush_seen_q <= flush_seen_d;
    end
  end

  assign core_bit   = (core_q != SQ_IDLE);
  assign core_req   = (core_q == SQ_DRAIN) || (core_q == SQ_CLEAR) || (core_q == SQ_FLUSH);
  assign bm_stop    = (core_q == SQ_DRAIN);
  assign sm_rst     = (core_q == SQ_CLEAR);
  assign fifo_flush = (core_q == SQ_CLEAR) || (core_q == SQ_FLUSH);
  assign fs_bit     = (fs_q != FS_IDLE);
  assign fs_req     = (fs_q == FS_REQ);

endmodule

// File: rtl/srs_phy.sv
module srs_phy #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_req,
  input  logic fs_req,
  input  logic busy,
  output logic usb_abort,
  output logic phy_sm_rst,
  output logic fs_sm_rst,
  output logic phy_ready,
  output logic core_ack,
  output logic fs_ack
);

  localparam int CNT_W = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD);

  logic [2:0]       sync_q;
  logic             req_s, fs_s, busy_s;
  logic             req_d1_q;
  logic [CNT_W-1:0] hold_q, hold_d;

  srs_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({busy, fs_req, core_req}),
    .q     (sync_q)
  );

  assign req_s  = sync_q[0];
  assign fs_s   = sync_q[1];
  assign busy_s = sync_q[2];

  always_comb begin
    hold_d = hold_q;
    if (busy_s)              hold_d = HOLD_V;
    else if (hold_q != '0)   hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d1_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      req_d1_q <= req_s;
      hold_q   <= hold_d;
    end
  end

  assign usb_abort  = req_s;
  assign phy_sm_rst = req_s & ~req_d1_q;
  assign fs_sm_rst  = fs_s;
  assign phy_ready  = ~busy_s & ~req_s & (hold_q == '0);
  assign core_ack   = req_s;
  assign fs_ack     = fs_s;

endmodule

// File: rtl/srs_regs.sv
module srs_regs
  import srs_pkg::*;
#(
  parameter int         INT_W    = 8,
  parameter logic [7:0] MISC_RST = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [15:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             clr,
  input  logic             core_bit,
  input  logic             fs_bit,
  input  logic             bm_idle,
  input  logic [INT_W-1:0] irq_set,
  output logic             irq_pending,
  output logic [1:0]       cfg_phy_clk,
  output logic [1:0]       cfg_dev_speed,
  output logic             cfg_soft_disc,
  output logic [7:0]       cfg_misc
);

  logic [4:0]       prot_q, prot_d;
  logic [7:0]       misc_q, misc_d;
  logic [INT_W-1:0] flag_q, flag_d;
  logic             cfg_we, int_we;
  logic [INT_W-1:0] w1c_mask;

  assign cfg_we   = wr && (addr == ADDR_CFG) && !clr;
  assign int_we   = wr && (addr == ADDR_INT);
  assign w1c_mask = int_we ? wdata[INT_W-1:0] : '0;

  always_comb begin
    prot_d = prot_q;
    misc_d = misc_q;
    if (clr) begin
      misc_d = MISC_RST;
    end else if (cfg_we) begin
      prot_d = wdata[4:0];
      misc_d = wdata[15:8];
    end
  end

  always_comb begin
    if (clr) flag_d = '0;
    else     flag_d = (flag_q & ~w1c_mask) | irq_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '0;
      misc_q <= MISC_RST;
      flag_q <= '0;
    end else begin
      prot_q <= prot_d;
      misc_q <= misc_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_CTRL: begin
        rdata[BIT_CORE] = core_bit;
        rdata[BIT_FS]   = fs_bit;
        rdata[BIT_IDLE] = bm_idle;
      end
      ADDR_CFG: rdata = {16'h0, misc_q, 3'b000, prot_q};
      ADDR_INT: rdata = 32'(flag_q);
      default:  rdata = '0;
    endcase
  end

  assign irq_pending   = |flag_q;
  assign cfg_phy_clk   = prot_q[1:0];
  assign cfg_dev_speed = prot_q[3:2];
  assign cfg_soft_disc = prot_q[4];
  assign cfg_misc      = misc_q;

endmodule

// File: rtl/softreset_seq.sv
module softreset_seq
  import srs_pkg::*;
#(
  parameter int         INT_W       = 8,
  parameter logic [7:0] MISC_RST    = 8'h5A,
  parameter int         SYNC_STAGES = 2,
  parameter int         PHY_HOLD    = 3
) (
  input  logic             clk_bus,
  input  logic             rst_bus_n,
  input  logic             clk_phy,
  input  logic             rst_phy_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [INT_W-1:0] irq_set,
  output logic             irq_pending,
  input  logic             bm_idle,
  output logic             bm_stop,
  output logic             sm_rst,
  output logic             fifo_flush,
  input  logic             fifo_flush_done,
  output logic             usb_abort,
  output logic             phy_sm_rst,
  output logic             fs_sm_rst,
  output logic             phy_ready,
  output logic [1:0]       cfg_phy_clk,
  output logic [1:0]       cfg_dev_speed,
  output logic             cfg_soft_disc,
  output logic [7:0]       cfg_misc
);

  logic        ctrl_we;
  logic        core_wr1, fs_wr1;
  logic        core_bit, fs_bit;
  logic        core_req, fs_req;
  logic        core_ack, fs_ack;
  logic        core_ack_s, fs_ack_s;
  logic [1:0]  ack_sync;
  logic [15:0] unused_wbits;

  assign unused_wbits = reg_wdata[31:16];

  assign ctrl_we  = reg_wr && (reg_addr == ADDR_CTRL);
  assign core_wr1 = ctrl_we && reg_wdata[BIT_CORE];
  assign fs_wr1   = ctrl_we && reg_wdata[BIT_FS];

  srs_seq u_seq (
    .clk        (clk_bus),
    .rst_n      (rst_bus_n),
    .core_wr1   (core_wr1),
    .fs_wr1     (fs_wr1),
    .bm_idle    (bm_idle),
    .flush_done (fifo_flush_done),
    .core_ack_s (core_ack_s),
    .fs_ack_s   (fs_ack_s),
    .core_bit   (core_bit),
    .fs_bit     (fs_bit),
    .core_req   (core_req),
    .fs_req     (fs_req),
    .bm_stop    (bm_stop),
    .sm_rst     (sm_rst),
    .fifo_flush (fifo_flush)
  );

  srs_regs #(.INT_W(INT_W), .MISC_RST(MISC_RST)) u_regs (
    .clk           (clk_bus),
    .rst_n         (rst_bus_n),
    .wr            (reg_wr),
    .addr          (reg_addr),
    .wdata         (reg_wdata[15:0]),
    .rdata         (reg_rdata),
    .clr           (sm_rst),
    .core_bit      (core_bit),
    .fs_bit        (fs_bit),
    .bm_idle       (bm_idle),
    .irq_set       (irq_set),
    .irq_pending   (irq_pending),
    .cfg_phy_clk   (cfg_phy_clk),
    .cfg_dev_speed (cfg_dev_speed),
    .cfg_soft_disc (cfg_soft_disc),
    .cfg_misc      (cfg_misc)
  );

  srs_phy #(.SYNC_STAGES(SYNC_STAGES), .HOLD(PHY_HOLD)) u_phy (
    .clk        (clk_phy),
    .rst_n      (rst_phy_n),
    .core_req   (core_req),
    .fs_req     (fs_req),
    .busy       (core_bit),
    .usb_abort  (usb_abort),
    .phy_sm_rst (phy_sm_rst),
    .fs_sm_rst  (fs_sm_rst),
    .phy_ready  (phy_ready),
    .core_ack   (core_ack),
    .fs_ack     (fs_ack)
  );

  srs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (clk_bus),
    .rst_n (rst_bus_n),
    .d     ({fs_ack, core_ack}),
    .q     (ack_sync)
  );

  assign core_ack_s = ack_sync[0];
  assign fs_ack_s   = ack_sync[1];

endmodule

// File: rtl/srs_chk.sv
module srs_chk (
  input logic       clk_bus,
  input logic       rst_bus_n,
  input logic       clk_phy,
  input logic       rst_phy_n,
  input logic       bm_idle,
  input logic       bm_stop,
  input logic       sm_rst,
  input logic       fifo_flush,
  input logic       core_bit,
  input logic       fs_bit,
  input logic       core_ack_s,
  input logic       irq_pending,
  input logic [1:0] cfg_phy_clk,
  input logic [1:0] cfg_dev_speed,
  input logic       cfg_soft_disc,
  input logic       usb_abort,
  input logic       phy_sm_rst,
  input logic       phy_ready
);

  assert_stop_only_busy_R3: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    bm_stop |-> core_bit);

  assert_stop_holds_R3: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (bm_stop && !bm_idle) |=> bm_stop);

  assert_pulse_after_idle_R4: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    $rose(sm_rst) |-> $past(bm_idle));

  assert_pulse_single_R4: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    sm_rst |=> !sm_rst);

  assert_flush_with_pulse_R4: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    sm_rst |-> fifo_flush);

  assert_keep_protected_R5: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    sm_rst |=> $stable({cfg_phy_clk, cfg_dev_speed, cfg_soft_disc}));

  assert_irq_cleared_R5: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    sm_rst |=> !irq_pending);

  assert_clear_after_ack_R7: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    $fell(core_bit) |-> !$past(core_ack_s));

  assert_fs_no_flush_R10: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (fs_bit && !core_bit) |-> (!fifo_flush && !sm_rst));

  assert_abort_blocks_R9: assert property (@(posedge clk_phy) disable iff (!rst_phy_n)
    usb_abort |-> !phy_ready);

  assert_phy_pulse_R6: assert property (@(posedge clk_phy) disable iff (!rst_phy_n)
    phy_sm_rst |=> !phy_sm_rst);

endmodule

bind softreset_seq srs_chk i_srs_chk (
  .clk_bus       (clk_bus),
  .rst_bus_n     (rst_bus_n),
  .clk_phy       (clk_phy),
  .rst_phy_n     (rst_phy_n),
  .bm_idle       (bm_idle),
  .bm_stop       (bm_stop),
  .sm_rst        (sm_rst),
  .fifo_flush    (fifo_flush),
  .core_bit      (core_bit),
  .fs_bit        (fs_bit),
  .core_ack_s    (core_ack_s),
  .irq_pending   (irq_pending),
  .cfg_phy_clk   (cfg_phy_clk),
  .cfg_dev_speed (cfg_dev_speed),
  .cfg_soft_disc (cfg_soft_disc),
  .usb_abort     (usb_abort),
  .phy_sm_rst    (phy_sm_rst),
  .phy_ready     (phy_ready)
);

// File: tb/test_softreset_seq.sv
`timescale 1ns/1ps
module test_softreset_seq;

  localparam int INT_W = 8;

  logic             clk_bus = 1'b0;
  logic             clk_phy = 1'b0;
  logic             rst_bus_n = 1'b0;
  logic             rst_phy_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic [1:0]       reg_addr = 2'd0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [INT_W-1:0] irq_set = '0;
  logic             irq_pending;
  logic             bm_idle = 1'b1;
  logic             bm_stop, sm_rst, fifo_flush;
  logic             fifo_flush_done = 1'b0;
  logic             usb_abort, phy_sm_rst, fs_sm_rst, phy_ready;
  logic [1:0]       cfg_phy_clk, cfg_dev_speed;
  logic             cfg_soft_disc;
  logic [7:0]       cfg_misc;

  always #2.5 clk_bus = ~clk_bus;
  always #3.5 clk_phy = ~clk_phy;

  softreset_seq i_softreset_seq (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_phy(clk_phy), .rst_phy_n(rst_phy_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_set(irq_set), .irq_pending(irq_pending), .bm_idle(bm_idle), .bm_stop(bm_stop),
    .sm_rst(sm_rst), .fifo_flush(fifo_flush), .fifo_flush_done(fifo_flush_done),
    .usb_abort(usb_abort), .phy_sm_rst(phy_sm_rst), .fs_sm_rst(fs_sm_rst),
    .phy_ready(phy_ready), .cfg_phy_clk(cfg_phy_clk), .cfg_dev_speed(cfg_dev_speed),
    .cfg_soft_disc(cfg_soft_disc), .cfg_misc(cfg_misc)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model state (bus domain)
  logic [15:0]      m_cfg = 16'h5A00;
  logic [INT_W-1:0] m_flags = '0;
  bit               m_drain = 0, m_pulse = 0, m_busy = 0, m_fs = 0;
  bit               m_flush_seen = 0;
  int               abort_at_trig = 0, fs_at_trig = 0;
  int               pulse_cnt = 0, flush_cycles = 0, clr_evt = 0;
  int               flush_delay = 0;

  // PHY-side observation counters
  int abort_cnt = 0, fs_cnt = 0, phy_pulse_cnt = 0;

  always @(negedge clk_bus) begin
    if (rst_bus_n) begin
      chk(bm_stop == m_drain, "R3 bm_stop", bm_stop, m_drain);
      chk(sm_rst == m_pulse, "R4 sm_rst", sm_rst, m_pulse);
      if (m_pulse) chk(fifo_flush == 1'b1, "R4 flush with pulse", fifo_flush, 1);
      chk(irq_pending == (|m_flags), "R11 irq_pending", irq_pending, |m_flags);
      if (sm_rst) pulse_cnt++;
      if (fifo_flush) flush_cycles++;
      if (fifo_flush && fifo_flush_done) m_flush_seen = 1;
      case (reg_addr)
        2'd0: begin
          chk(reg_rdata[31] == bm_idle, "R8 idle bit", reg_rdata[31], bm_idle);
          chk(reg_rdata[30:2] == '0, "R1 ctrl zero bits", reg_rdata[30:2], 0);
          if (m_busy && !reg_rdata[0]) begin
            chk(m_flush_seen, "R7 clear before flush done", 0, 1);
            chk(abort_cnt > abort_at_trig, "R7 clear before phy ack", abort_cnt, abort_at_trig + 1);
            m_busy = 0;
            clr_evt++;
          end else chk(reg_rdata[0] == m_busy, "R2 core bit", reg_rdata[0], m_busy);
          if (m_fs && !reg_rdata[1]) begin
            chk(fs_cnt > fs_at_trig, "R10 fs clear before phy", fs_cnt, fs_at_trig + 1);
            m_fs = 0;
          end else chk(reg_rdata[1] == m_fs, "R10 fs bit", reg_rdata[1], m_fs);
        end
        2'd1: chk(reg_rdata == {16'h0, m_cfg}, "R5 cfg word", reg_rdata, m_cfg);
        2'd2: chk(reg_rdata == 32'(m_flags), "R11 flags", reg_rdata, m_flags);
        default: ;
      endcase
      // advance model to state after the next rising edge
      begin
        bit old_drain, old_pulse;
        old_drain = m_drain;
        old_pulse = m_pulse;
        if (old_pulse) begin
          m_cfg   = {8'h5A, 3'b000, m_cfg[4:0]};
          m_flags = '0;
          m_pulse = 0;
        end else begin
          if (reg_wr && reg_addr == 2'd1) m_cfg = {reg_wdata[15:8], 3'b000, reg_wdata[4:0]};
          m_flags = (m_flags & ~((reg_wr && reg_addr == 2'd2) ? reg_wdata[INT_W-1:0] : '0)) | irq_set;
        end
        if (old_drain && bm_idle) begin
          m_drain = 0;
          m_pulse = 1;
        end
        if (reg_wr && reg_addr == 2'd0 && reg_wdata[0] && !m_busy) begin
          m_busy = 1; m_drain = 1; m_flush_seen = 0; abort_at_trig = abort_cnt;
        end
        if (reg_wr && reg_addr == 2'd0 && reg_wdata[1] && !m_fs) begin
          m_fs = 1; fs_at_trig = fs_cnt;
        end
      end
    end
  end

  // PHY domain monitor
  int  seen_evt = 0;
  int  since = 0;
  bit  hold_active = 0;
  always @(posedge clk_phy) begin
    if (clr_evt != seen_evt) begin
      seen_evt = clr_evt; since = 0; hold_active = 1;
    end else if (hold_active) since++;
  end
  always @(negedge clk_phy) begin
    if (rst_phy_n) begin
      if (usb_abort) begin
        abort_cnt++;
        chk(!phy_ready, "R9 ready during abort", phy_ready, 0);
      end
      if (fs_sm_rst) fs_cnt++;
      if (phy_sm_rst) phy_pulse_cnt++;
      if (hold_active && phy_ready) begin
        chk(since >= 3, "R9 hold after clear", since, 3);
        hold_active = 0;
      end
    end
  end

  // FIFO stub: answers a flush after flush_delay cycles
  int fcnt = 0;
  always @(posedge clk_bus) begin
    #1;
    if (!fifo_flush) begin fcnt = 0; fifo_flush_done = 1'b0; end
    else begin
      if (fcnt >= flush_delay) fifo_flush_done = 1'b1;
      fcnt++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_bus);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk_bus); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk_bus); #1;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk_bus); #1;
    reg_addr = a;
    @(negedge clk_bus);
    d = reg_rdata;
    @(posedge clk_bus); #1;
    reg_addr = 2'd0;
  endtask

  task automatic wait_bit_clear(input int idx, input string req);
    bit done = 0;
    for (int i = 0; i < 400 && !done; i++) begin
      @(negedge clk_bus);
      if (reg_addr == 2'd0 && !reg_rdata[idx]) done = 1;
    end
    chk(done, req, done, 1);
    cyc(1);
  endtask

  task automatic run_core_reset(input int drain_cycles, input int fdelay, input bit rewrite);
    logic [31:0] d;
    int p0, a0, ph0;
    p0 = pulse_cnt; a0 = abort_cnt; ph0 = phy_pulse_cnt;
    flush_delay = fdelay;
    bm_idle = (drain_cycles == 0);
    wr(2'd0, 32'h1);
    if (drain_cycles > 0) begin
      cyc(1);
      chk(bm_stop, "R3 stop asserted", bm_stop, 1);
      cyc(6);
      // USB side aborted while bus master still draining
      chk(abort_cnt > a0, "R6 abort before drain ends", abort_cnt, a0 + 1);
      chk(pulse_cnt == p0, "R4 no pulse while draining", pulse_cnt, p0);
      if (rewrite) wr(2'd0, 32'h1);
      if (drain_cycles > 9) cyc(drain_cycles - 9);
      bm_idle = 1'b1;
    end
    wait_bit_clear(0, "R7 core bit self-clears");
    chk(pulse_cnt == p0 + 1, "R2 one pulse per reset", pulse_cnt, p0 + 1);
    chk(phy_pulse_cnt == ph0 + 1, "R6 one phy pulse", phy_pulse_cnt, ph0 + 1);
    rd(2'd1, d);
    chk(d[15:8] == 8'h5A, "R5 misc back to reset", d[15:8], 8'h5A);
    cyc(12);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_bus);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int f0, p0;
    #12;
    @(posedge clk_bus); #1;
    rst_bus_n = 1'b1; rst_phy_n = 1'b1;
    cyc(3);
    // R1 reset state
    rd(2'd0, d);
    chk(d == 32'h8000_0000, "R1 ctrl after reset", d, 32'h8000_0000);
    rd(2'd1, d);
    chk(d == 32'h0000_5A00, "R1 cfg after reset", d, 32'h5A00);
    rd(2'd2, d);
    chk(d == 0, "R1 flags after reset", d, 0);
    chk(!bm_stop && !sm_rst && !fifo_flush, "R1 outputs idle", {bm_stop, sm_rst, fifo_flush}, 0);
    cyc(4);
    chk(phy_ready, "R9 ready when quiet", phy_ready, 1);

    // R8 live idle bit, R2 write of zero ignored
    bm_idle = 1'b0;
    wr(2'd0, 32'h8000_0000);
    cyc(3);
    rd(2'd0, d);
    chk(d == 32'h0, "R8 idle bit follows input / R2 write 0 ignored", d, 0);
    chk(pulse_cnt == 0 && !bm_stop, "R2 no reset from write 0", pulse_cnt, 0);
    bm_idle = 1'b1;

    // configuration and interrupts
    wr(2'd1, 32'h0000_C31B);
    rd(2'd1, d);
    chk(d == 32'h0000_C31B, "R5 cfg written", d, 32'hC31B);
    @(posedge clk_bus); #1; irq_set = 8'hA5;
    @(posedge clk_bus); #1; irq_set = 8'h00;
    rd(2'd2, d);
    chk(d == 32'hA5, "R11 flags set", d, 32'hA5);
    wr(2'd2, 32'h05);
    rd(2'd2, d);
    chk(d == 32'hA0, "R11 w1c", d, 32'hA0);

    // long drain, slow flush, second write during reset
    run_core_reset(20, 6, 1'b1);
    rd(2'd1, d);
    chk(d == 32'h0000_5A1B, "R5 protected kept", d, 32'h5A1B);
    rd(2'd2, d);
    chk(d == 0, "R5 flags cleared", d, 0);

    // idle master, immediate flush
    @(posedge clk_bus); #1; irq_set = 8'h3C;
    @(posedge clk_bus); #1; irq_set = 8'h00;
    wr(2'd1, 32'h0000_7707);
    run_core_reset(0, 0, 1'b0);
    rd(2'd1, d);
    chk(d == 32'h0000_5A07, "R5 protected kept again", d, 32'h5A07);

    // idle master, very slow flush
    run_core_reset(0, 30, 1'b0);

    // full-speed interface reset only
    f0 = flush_cycles; p0 = pulse_cnt;
    wr(2'd1, 32'h0000_9911);
    wr(2'd0, 32'h2);
    wait_bit_clear(1, "R10 fs bit self-clears");
    chk(fs_cnt > 0, "R10 fs reset reached phy", fs_cnt, 1);
    chk(flush_cycles == f0 && pulse_cnt == p0, "R10 no flush or pulse", flush_cycles - f0, 0);
    rd(2'd1, d);
    chk(d == 32'h0000_9911, "R10 regs untouched", d, 32'h9911);

    cyc(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule